// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer split across two clocks. Software on a bus clock writes 32-bit words to a small register file. The down-counter that decides when the system must be reset runs on a separate, slow and free-running clock. The prescaler and reload registers are normally write-protected. A fixed 16-bit unlock value written to the key register lifts that protection. Other values written to the same key register start the counter or refresh it.

Each configuration value written on the bus side is handed to the slow domain through a toggle handshake. A status bit stays high for each value that has not yet been taken over. When a prescaled tick finds the counter already at zero, the block raises a reset request for one slow-clock cycle and reloads the counter. An early-warning interrupt can be raised at a programmable count before expiry. It has a software enable and a write-one-to-clear bit.

Software unlocks the registers and programs the divider and the reload value. It waits for the status bits to drop and then writes the start value. After that it must write the refresh value more often than one full timeout period, or the reset request fires.

Top module: `kwdt_top`

## Requirements
- R1: After reset the prescaler register (offset 0x04) reads 0, the reload register (offset 0x08) reads 0xFFF, status (offset 0x0C) and early-warning control (offset 0x14) read 0, `ew_irq` and `rst_req` are low, and no reset request is produced while the counter has not been started.
- R2: The prescaler and reload registers start locked, and writes to them while locked are ignored. Writing 0x00005555 to the key register (offset 0x00) unlocks them. Any other value written to the key register locks them again.
- R3: The prescaler field is bits 3:0. Code k from 0 to 6 divides the slow clock by 4·2^k, and codes 7 to 15 divide it by 256.
- R4: Writing 0x0000CCCC to the key register starts the counter from the reload value (bits 11:0). The counter decrements once per prescaled tick. A tick at count zero raises `rst_req` for exactly one slow-clock cycle and reloads the counter, so expiries repeat every (reload+1)·divider slow cycles.
- R5: Once started, the counter keeps running. Later key writes of any value, including ones that relock the registers, do not stop it.
- R6: Writing 0x0000AAAA to the key register reloads the counter from the reload value. Refreshing more often than one timeout period prevents any `rst_req`.
- R7: Status bit 0 (prescaler), bit 1 (reload) and bit 3 (early-warning compare) go high in the cycle after an accepted write to that register. Each falls once the value has been taken over by the slow domain. Bit 2 always reads 0.
- R8: A write to the prescaler, reload or early-warning compare field while its status bit is high is ignored.
- R9: Early-warning control bits 11:0 hold a compare value and bit 15 is the enable. When the counter decrements to the compare value with the enable set, `ew_irq` goes high and stays high.
- R10: Writing early-warning control with bit 14 set clears `ew_irq` in the next cycle. Bit 14 always reads back 0.
- R11: With the early-warning enable clear, `ew_irq` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| ew_irq | output | 1 | Early-warning interrupt flag, bus domain |
| slow_clk | input | 1 | Watchdog counting clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| rst_req | output | 1 | One slow-cycle reset request on expiry |

## Verification
The bench measures the slow-cycle distance between consecutive expiries for several divider codes, including one above 6. A wrong divider mapping or an off-by-one in the zero tick would shift that distance by a whole tick or a power of two. It writes a register twice back to back, so that the second write lands while the first is still crossing. A design that did not ignore it would read back the second value and could capture a torn value in the slow domain. It also relocks the registers after the start, refreshes in a loop, and toggles the early-warning enable. In these tests a watchdog that could be stopped, a refresh that failed to land, or a flag that rose while disabled would each show up as an expiry pulse, or as a flag level that the cycle-by-cycle register model does not predict.

// File: rtl/kwdt_pkg.sv
// Shared constants of the key-protected watchdog: register offsets, key
// values, field positions and handshake channel indices.
package kwdt_pkg;
    localparam int OFS_KEY = 0;
    localparam int OFS_PRE = 4;
    localparam int OFS_RLD = 8;
    localparam int OFS_STS = 12;
    localparam int OFS_EWC = 20;

    localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_START   = 16'hCCCC;

    localparam int EW_EN_BIT   = 15;
    localparam int EW_CLR_BIT  = 14;
    localparam int STS_PRE_BIT = 0;
    localparam int STS_RLD_BIT = 1;
    localparam int STS_EWC_BIT = 3;

    // Handshake channels from bus to slow domain
    localparam int CH_PRE     = 0;
    localparam int CH_RLD     = 1;
    localparam int CH_EWC     = 2;
    localparam int CH_START   = 3;
    localparam int CH_REFRESH = 4;
    localparam int NCH        = 5;
endpackage

// File: rtl/kwdt_xfer.sv
// Toggle handshake carrying one event from the bus domain to the slow domain.
// Assumes the sender never launches while busy is high and keeps the
// associated data stable until busy drops.
module kwdt_xfer (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic launch,
    output logic busy,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_stb
);
    logic req_tog, ack_s1, ack_s2;
    logic req_s1, req_s2, req_s3;

    // Flip the request on each launch and sample the returned acknowledge
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            req_tog <= 1'b0;
            ack_s1  <= 1'b0;
            ack_s2  <= 1'b0;
        end else begin
            if (launch) req_tog <= ~req_tog;
            ack_s1 <= req_s3;
            ack_s2 <= ack_s1;
        end
    end

    // Synchronise the request; the last stage doubles as the acknowledge
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
        end else begin
            req_s1 <= req_tog;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
        end
    end

    assign dst_stb = req_s2 ^ req_s3;
    assign busy    = req_tog ^ ack_s2;

    // R7
    pend_set_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (launch && !busy) |=> busy);
endmodule

// File: rtl/kwdt_evsync.sv
// Carries single-cycle events from the slow domain to the bus domain.
// Assumes events are many destination cycles apart.
module kwdt_evsync (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tog, s1, s2, s3;

    // Turn each source event into a level change
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) tog <= 1'b0;
        else if (src_pulse) tog <= ~tog;
    end

    // Synchronise the level and detect its changes
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= tog;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign dst_pulse = s2 ^ s3;
endmodule

// File: rtl/kwdt_core.sv
// Slow-domain engine: shadow copies of the configuration, the prescaler,
// the down-counter, expiry and early-warning detection.
// Assumes each strobe marks bus-side data that is stable at that moment.
module kwdt_core #(
    parameter int PR_W     = 4,
    parameter int CNT_W    = 12,
    parameter int MAX_CODE = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [kwdt_pkg::NCH-1:0]  chan_stb,
    input  logic [PR_W-1:0]           pre_src,
    input  logic [CNT_W-1:0]          rld_src,
    input  logic [CNT_W-1:0]          ewc_src,
    output logic                      rst_req,
    output logic                      ew_hit
);
    import kwdt_pkg::*;

    localparam int PCNT_W = MAX_CODE + 2;

    logic [PR_W-1:0]   pre_sh;
    logic [CNT_W-1:0]  rld_sh, ewc_sh, cnt;
    logic [PCNT_W-1:0] pcnt, div_last;
    logic [PR_W-1:0]   shift;
    logic              running, tick, cmd;

    // Clamp the divider code and derive the last prescaler count
    always_comb begin
        shift    = (pre_sh > PR_W'(MAX_CODE)) ? PR_W'(MAX_CODE) : pre_sh;
        div_last = PCNT_W'((32'd1 << (32'(shift) + 32'd2)) - 32'd1);
        tick     = running && (pcnt >= div_last);
        cmd      = chan_stb[CH_START] | chan_stb[CH_REFRESH];
    end

    // Take over configuration values when their handshake arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_sh <= '0;
            rld_sh <= '1;
            ewc_sh <= '0;
        end else begin
            if (chan_stb[CH_PRE]) pre_sh <= pre_src;
            if (chan_stb[CH_RLD]) rld_sh <= rld_src;
            if (chan_stb[CH_EWC]) ewc_sh <= ewc_src;
        end
    end

    // Prescale, count down, expire and flag the early-warning point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            pcnt    <= '0;
            rst_req <= 1'b0;
            ew_hit  <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            ew_hit  <= 1'b0;
            if (chan_stb[CH_START]) running <= 1'b1;
            if (cmd) begin
                cnt  <= rld_sh;
                pcnt <= '0;
            end else if (running) begin
                if (tick) begin
                    pcnt <= '0;
                    if (cnt == '0) begin
                        cnt     <= rld_sh;
                        rst_req <= 1'b1;
                    end else begin
                        cnt    <= cnt - CNT_W'(1);
                        ew_hit <= ((cnt - CNT_W'(1)) == ewc_sh);
                    end
                end else begin
                    pcnt <= pcnt + PCNT_W'(1);
                end
            end
        end
    end

    // R4
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R5
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
endmodule

// File: rtl/kwdt_regs.sv
// Bus-domain register file: key decoding, write protection, the
// configuration registers, status readout and the early-warning flag.
// Assumes one write per wr_en cycle and word-aligned byte offsets.
module kwdt_regs #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int PR_W   = 4,
    parameter int CNT_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic [PR_W-1:0]           pre_q,
    output logic [CNT_W-1:0]          rld_q,
    output logic [CNT_W-1:0]          ewc_q,
    input  logic [kwdt_pkg::NCH-1:0]  chan_busy,
    output logic [kwdt_pkg::NCH-1:0]  chan_launch,
    input  logic                      ew_evt,
    output logic                      ew_irq
);
    import kwdt_pkg::*;

    logic unlocked, ew_en;
    logic wr_key, wr_pre, wr_rld, wr_ewc;
    logic acc_pre, acc_rld, acc_ewc;

    // Decode writes and decide which of them are accepted
    always_comb begin
        wr_key  = wr_en && (wr_addr == ADDR_W'(OFS_KEY));
        wr_pre  = wr_en && (wr_addr == ADDR_W'(OFS_PRE));
        wr_rld  = wr_en && (wr_addr == ADDR_W'(OFS_RLD));
        wr_ewc  = wr_en && (wr_addr == ADDR_W'(OFS_EWC));
        acc_pre = wr_pre && unlocked && !chan_busy[CH_PRE];
        acc_rld = wr_rld && unlocked && !chan_busy[CH_RLD];
        acc_ewc = wr_ewc && !chan_busy[CH_EWC];
        chan_launch = '0;
        chan_launch[CH_PRE]     = acc_pre;
        chan_launch[CH_RLD]     = acc_rld;
        chan_launch[CH_EWC]     = acc_ewc;
        chan_launch[CH_START]   = wr_key && (wr_data == DATA_W'(KEY_START))
                                  && !chan_busy[CH_START];
        chan_launch[CH_REFRESH] = wr_key && (wr_data == DATA_W'(KEY_REFRESH))
                                  && !chan_busy[CH_REFRESH];
    end

    // Track the write-protection state from key writes
    always_ff @(posedge clk) begin
        if (!rst_n) unlocked <= 1'b0;
        else if (wr_key) unlocked <= (wr_data == DATA_W'(KEY_UNLOCK));
    end

    // Hold the configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            rld_q <= '1;
            ewc_q <= '0;
            ew_en <= 1'b0;
        end else begin
            if (acc_pre) pre_q <= wr_data[PR_W-1:0];
            if (acc_rld) rld_q <= wr_data[CNT_W-1:0];
            if (acc_ewc) ewc_q <= wr_data[CNT_W-1:0];
            if (wr_ewc)  ew_en <= wr_data[EW_EN_BIT];
        end
    end

    // Set the early-warning flag on an enabled event; a clear write wins
    always_ff @(posedge clk) begin
        if (!rst_n) ew_irq <= 1'b0;
        else if (wr_ewc && wr_data[EW_CLR_BIT]) ew_irq <= 1'b0;
        else if (ew_evt && ew_en) ew_irq <= 1'b1;
    end

    // Return the addressed register
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_PRE)) begin
            rd_data[PR_W-1:0] = pre_q;
        end else if (rd_addr == ADDR_W'(OFS_RLD)) begin
            rd_data[CNT_W-1:0] = rld_q;
        end else if (rd_addr == ADDR_W'(OFS_STS)) begin
            rd_data[STS_PRE_BIT] = chan_busy[CH_PRE];
            rd_data[STS_RLD_BIT] = chan_busy[CH_RLD];
            rd_data[STS_EWC_BIT] = chan_busy[CH_EWC];
        end else if (rd_addr == ADDR_W'(OFS_EWC)) begin
            rd_data[CNT_W-1:0] = ewc_q;
            rd_data[EW_EN_BIT] = ew_en;
        end
    end

    // R2
    locked_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pre && !unlocked) |=> $stable(pre_q));
    // R8
    busy_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rld && chan_busy[CH_RLD]) |=> $stable(rld_q));
    // R9
    ew_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ew_irq && !(wr_ewc && wr_data[EW_CLR_BIT])) |=> ew_irq);
    // R10
    ew_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ewc && wr_data[EW_CLR_BIT]) |=> !ew_irq);
    // R11
    ew_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ew_en && !ew_irq) |=> !ew_irq);
endmodule

// File: rtl/kwdt_top.sv
// Key-protected watchdog top: bus register file, one handshake per
// configuration value or command, the slow-domain counter and the event
// return path. Assumes both resets are asserted together at power-up.
module kwdt_top #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int PR_W   = 4,
    parameter int CNT_W  = 12
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ew_irq,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    output logic              rst_req
);
    import kwdt_pkg::*;

    logic [NCH-1:0]   chan_launch, chan_busy, chan_stb;
    logic [PR_W-1:0]  pre_q;
    logic [CNT_W-1:0] rld_q, ewc_q;
    logic             ew_hit, ew_evt;

    kwdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PR_W(PR_W), .CNT_W(CNT_W)) u_regs (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pre_q(pre_q), .rld_q(rld_q), .ewc_q(ewc_q),
        .chan_busy(chan_busy), .chan_launch(chan_launch),
        .ew_evt(ew_evt), .ew_irq(ew_irq)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_xfer
        kwdt_xfer u_xfer (
            .src_clk(bus_clk), .src_rst_n(bus_rst_n),
            .launch(chan_launch[ch]), .busy(chan_busy[ch]),
            .dst_clk(slow_clk), .dst_rst_n(slow_rst_n),
            .dst_stb(chan_stb[ch])
        );
    end

    kwdt_core #(.PR_W(PR_W), .CNT_W(CNT_W)) u_core (
        .clk(slow_clk), .rst_n(slow_rst_n),
        .chan_stb(chan_stb),
        .pre_src(pre_q), .rld_src(rld_q), .ewc_src(ewc_q),
        .rst_req(rst_req), .ew_hit(ew_hit)
    );

    kwdt_evsync u_evsync (
        .src_clk(slow_clk), .src_rst_n(slow_rst_n), .src_pulse(ew_hit),
        .dst_clk(bus_clk), .dst_rst_n(bus_rst_n), .dst_pulse(ew_evt)
    );
endmodule

// File: tb/test_kwdt_top.sv
module test_kwdt_top;
    logic        bclk = 1'b0, sclk = 1'b0;
    logic        brst_n = 1'b0, srst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_addr = 5'd4;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ew_irq, rst_req;

    kwdt_top i_kwdt_top (
        .bus_clk(bclk), .bus_rst_n(brst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ew_irq(ew_irq),
        .slow_clk(sclk), .slow_rst_n(srst_n), .rst_req(rst_req)
    );

    localparam logic [4:0] A_KEY = 5'd0, A_PRE = 5'd4, A_RLD = 5'd8,
                           A_STS = 5'd12, A_EWC = 5'd20;

    always #5 bclk = ~bclk;
    initial begin #3; forever #40 sclk = ~sclk; end

    int errors = 0, checks = 0;
    bit done = 0;

    // Behavioural register model
    bit       m_unl = 0;
    bit [2:0] m_pend = '0;
    int       m_pre = 0, m_rld = 'hFFF, m_ewc = 0, m_en = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expiry pulse monitor in the slow domain
    int scyc = 0;
    int ptimes[$];
    bit prev_hi = 0;
    always @(posedge sclk) scyc++;
    always @(negedge sclk) begin
        if (srst_n) begin
            if (rst_req) begin
                check(!prev_hi, "R4 pulse width", 2, 1);
                ptimes.push_back(scyc);
            end
            prev_hi = rst_req;
        end
    end

    // Per-clock comparison of register readback against the model
    always @(negedge bclk) begin
        #3;
        if (brst_n && !done) begin
            if (rd_addr == A_PRE) check(rd_data == 32'(m_pre), "R2 model prescaler", rd_data, m_pre);
            else if (rd_addr == A_RLD) check(rd_data == 32'(m_rld), "R2 model reload", rd_data, m_rld);
            else if (rd_addr == A_EWC) check(rd_data == 32'((m_en << 15) | m_ewc), "R9 model ewcr",
                                             rd_data, (m_en << 15) | m_ewc);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge bclk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge bclk);
        #1;
        if (a == A_KEY) m_unl = (d == 32'h5555);
        else if (a == A_PRE && m_unl && !m_pend[0]) begin m_pre = int'(d[3:0]); m_pend[0] = 1; end
        else if (a == A_RLD && m_unl && !m_pend[1]) begin m_rld = int'(d[11:0]); m_pend[1] = 1; end
        else if (a == A_EWC) begin
            m_en = int'(d[15]);
            if (!m_pend[2]) begin m_ewc = int'(d[11:0]); m_pend[2] = 1; end
        end
        @(negedge bclk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge bclk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] s;
        int n = 0;
        rd(A_STS, s);
        while ((s & 32'hB) != 0 && n < 500) begin rd(A_STS, s); n++; end
        check((s & 32'hF) == 0, tag, s, 0);
        m_pend = '0;
        rd_addr = A_PRE;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge bclk);
    endtask

    task automatic measure(input int exp, input string tag);
        int base = ptimes.size();
        int n = 0;
        while (ptimes.size() < base + 3 && n < 60000) begin @(posedge bclk); n++; end
        if (ptimes.size() >= base + 3)
            check(ptimes[base+2] - ptimes[base+1] == exp, tag, ptimes[base+2] - ptimes[base+1], exp);
        else
            check(0, {tag, " no pulses"}, ptimes.size() - base, 3);
    endtask

    task automatic set_cfg(input int pre, input int rld);
        wr(A_KEY, 32'h5555);
        wr(A_PRE, 32'(pre));
        wr(A_RLD, 32'(rld));
        wait_idle("R7 status clears");
    endtask

    initial begin
        logic [31:0] v;
        int n0;
        repeat (6) @(posedge sclk);
        @(negedge bclk); brst_n = 1'b1;
        @(negedge sclk); srst_n = 1'b1;
        // R1 reset state
        rd(A_PRE, v); check(v == 0, "R1 prescaler reset", v, 0);
        rd(A_RLD, v); check(v == 32'hFFF, "R1 reload reset", v, 32'hFFF);
        rd(A_STS, v); check(v == 0, "R1 status reset", v, 0);
        rd(A_EWC, v); check(v == 0, "R1 ewcr reset", v, 0);
        check(ew_irq == 0, "R1 irq reset", ew_irq, 0);
        check(rst_req == 0, "R1 rst_req reset", rst_req, 0);
        rd_addr = A_PRE;
        // R2 locked write ignored
        wr(A_PRE, 32'd3);
        rd(A_PRE, v); check(v == 0, "R2 locked write", v, 0);
        // R2 unlock, R7 pending flag next cycle
        wr(A_KEY, 32'h5555);
        wr(A_PRE, 32'd3);
        rd(A_STS, v); check(v == 32'h1, "R7 prescaler pending", v, 1);
        rd(A_PRE, v); check(v == 3, "R2 unlocked write", v, 3);
        wait_idle("R7 prescaler settles");
        // R8 write while pending ignored
        wr(A_RLD, 32'h123);
        rd(A_STS, v); check(v == 32'h2, "R7 reload pending", v, 2);
        wr(A_RLD, 32'h456);
        rd(A_RLD, v); check(v == 32'h123, "R8 busy write", v, 32'h123);
        wait_idle("R7 reload settles");
        // R2 relock by another key
        wr(A_KEY, 32'h1234);
        wr(A_PRE, 32'd1);
        rd(A_PRE, v); check(v == 3, "R2 relocked write", v, 3);
        rd_addr = A_PRE;
        // R1 nothing fires before start
        idle(2000);
        check(ptimes.size() == 0, "R1 no expiry before start", ptimes.size(), 0);
        // R4 start and expiry period, code 0 divides by 4
        set_cfg(0, 5);
        wr(A_KEY, 32'hCCCC);
        measure(24, "R4 period code0 reload5");
        // R3 other divider codes
        set_cfg(1, 3);
        measure(32, "R3 period code1 reload3");
        set_cfg(9, 3);
        measure(1024, "R3 period code9 reload3");
        set_cfg(2, 2);
        measure(48, "R3 period code2 reload2");
        // R5 key writes do not stop it
        wr(A_KEY, 32'h0);
        wr(A_KEY, 32'hFFFF);
        n0 = ptimes.size();
        idle(1200);
        check(ptimes.size() - n0 >= 2, "R5 keeps running", ptimes.size() - n0, 2);
        // R6 refresh holds off expiry (84 slow cycles = 672 bus cycles)
        set_cfg(0, 20);
        n0 = ptimes.size();
        while (ptimes.size() == n0) @(posedge bclk);
        n0 = ptimes.size();
        for (int i = 0; i < 20; i++) begin wr(A_KEY, 32'hAAAA); idle(200); end
        check(ptimes.size() == n0, "R6 refresh prevents expiry", ptimes.size() - n0, 0);
        idle(1500);
        check(ptimes.size() > n0, "R6 expiry resumes", ptimes.size() - n0, 1);
        // R11 disabled early warning
        wr(A_EWC, 32'h00A);
        wait_idle("R7 ewcr settles");
        idle(1500);
        check(ew_irq == 0, "R11 irq stays low", ew_irq, 0);
        // R9 enabled early warning
        wr(A_EWC, 32'h800A);
        wait_idle("R7 ewcr settles");
        n0 = ptimes.size();
        while (ptimes.size() < n0 + 2) @(posedge bclk);
        @(negedge bclk);
        check(ew_irq == 1, "R9 irq set", ew_irq, 1);
        rd(A_EWC, v); check(v == 32'h800A, "R9 ewcr readback", v, 32'h800A);
        // R10 clear and bit 14 reads zero
        wr(A_EWC, 32'h400A);
        check(ew_irq == 0, "R10 irq cleared", ew_irq, 0);
        rd(A_EWC, v); check(v == 32'h000A, "R10 clear bit reads 0", v, 32'h000A);
        wait_idle("R7 ewcr settles");
        idle(1500);
        check(ew_irq == 0, "R11 irq low after disable", ew_irq, 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge bclk);
        if (!done) begin
            done = 1;
            check(0, "watchdog timeout", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule